// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Aligner

This block sits between an instruction fetch stream that delivers one 32-bit, word-aligned fetch word per handshake and the decoder. It splits each fetch word into two 16-bit parcels and keeps them in a small queue. It works out the length of the instruction at the head of the queue from the low bits of the head parcel. When an instruction is complete, it offers exactly one 16-bit or 32-bit instruction per cycle, together with its PC and a length flag.

Instructions can start on any halfword boundary, so a 32-bit instruction may begin in the upper half of one fetch word and end in the lower half of the next. Encodings of 48 bits or more are never assembled. Such a head raises an unsupported flag and halts issue until the fetch side is steered elsewhere. A redirect input empties the queue and loads a new halfword-aligned PC. If that PC points at the upper half of a word, the lower parcel of the first word fetched afterwards is thrown away.

Top module: `parcel_aligner`

## Requirements
- R1: After reset, out_valid and unsupported are 0, fetch_ready is 1 and out_pc equals the RESET_PC parameter.
- R2: A head parcel whose bits [1:0] are not 2'b11 is a 16-bit instruction. It is offered with out_len32 = 0, and out_instr carries the parcel in bits [15:0] with bits [31:16] set to zero.
- R3: A head parcel with bits [1:0] = 2'b11 and bits [4:2] not equal to 3'b111 is a 32-bit instruction. It is offered with out_len32 = 1 once both parcels are held. The parcel at the lower address fills out_instr[15:0] and the next parcel fills out_instr[31:16].
- R4: A 32-bit instruction that starts at a PC with bit 1 set is assembled from the upper half of one fetch word and the lower half of the next fetch word. Parcels of a fetch word are ordered low half first: bits [15:0] sit at the word address and bits [31:16] at the word address + 2.
- R5: Each accepted output advances out_pc by 2 for a 16-bit instruction and by 4 for a 32-bit instruction.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_instr and out_pc stay unchanged in the next cycle.
- R7: A redirect empties the queue and loads out_pc with redirect_pc (bit 0 forced to 0). Any output or fetch handshake in the redirect cycle is ignored. The next instruction offered is the one at that PC.
- R8: After a redirect to a PC with bit 1 set, the lower parcel of the first fetch word accepted afterwards is dropped. The first instruction offered therefore starts with that word's bits [31:16].
- R9: A head parcel with bits [1:0] = 2'b11 and bits [4:2] = 3'b111 raises unsupported and keeps out_valid at 0. This covers the 48-bit, 64-bit and longer encodings. The condition persists until a redirect.
- R10: fetch_ready is 1 exactly when the queue holds at most two parcels. With out_ready held at 0 after a redirect, exactly two fetch words are accepted, whatever the target's bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch word is offered |
| fetch_ready | output | 1 | Queue can take a fetch word |
| fetch_word | input | 32 | Word-aligned fetch data, low parcel in [15:0] |
| redirect | input | 1 | Flush and restart at redirect_pc |
| redirect_pc | input | PC_W | New halfword-aligned PC |
| out_valid | output | 1 | A complete instruction is offered |
| out_ready | input | 1 | Decoder takes the instruction |
| out_instr | output | 32 | Instruction, upper half zero when 16-bit |
| out_pc | output | PC_W | PC of the offered instruction |
| out_len32 | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| unsupported | output | 1 | Head encodes 48 bits or more; issue halted |

## Verification
If the queue count, the dropped-parcel flag or the head PC goes wrong, the error shows at the ports by the next accepted instruction. It appears as a wrong halfword in out_instr, a wrong length flag or an out_pc off by 2. The bench recomputes every expected instruction from the fetch memory at the expected PC. It redirects to both even and odd halfword targets while fetch and decoder stalls are random, so a misplaced parcel or a lost straddling half is caught on the first instruction that touches it. A broken stall path shows within one cycle, as a changed output under back-pressure or as a third accepted fetch word.

// File: rtl/parcel_aligner.sv
module parcel_aligner #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  output logic            fetch_ready,
  input  logic [31:0]     fetch_word,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirect_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_instr,
  output logic [PC_W-1:0] out_pc,
  output logic            out_len32,
  output logic            unsupported
);

  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic [15:0]     pq [DEPTH];
  logic [15:0]     nq [DEPTH];
  logic [CW-1:0]   cnt, ncnt, base, pop;
  logic [PC_W-1:0] pc_q;
  logic            skip_lo;

  wire [15:0] head = pq[0];
  wire is16 = head[1:0] != 2'b11;
  wire is32 = head[1:0] == 2'b11 && head[4:2] != 3'b111;

  assign out_valid   = (cnt >= CW'(1) && is16) || (cnt >= CW'(2) && is32);
  assign unsupported = cnt != '0 && !is16 && !is32;
  assign out_len32   = !is16;
  assign out_instr   = is16 ? {16'h0000, head} : {pq[1], head};
  assign out_pc      = pc_q;
  assign fetch_ready = cnt <= CW'(DEPTH - 2);

  wire fire = out_valid && out_ready && !redirect;
  wire take = fetch_valid && fetch_ready && !redirect;

  assign pop  = fire ? (is16 ? CW'(1) : CW'(2)) : '0;
  assign base = cnt - pop;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nq[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (j == i + int'(pop)) nq[i] = pq[j];
      if (take) begin
        if (skip_lo) begin
          if (i == int'(base)) nq[i] = fetch_word[31:16];
        end else begin
          if (i == int'(base))     nq[i] = fetch_word[15:0];
          if (i == int'(base) + 1) nq[i] = fetch_word[31:16];
        end
      end
    end
    ncnt = base + (take ? (skip_lo ? CW'(1) : CW'(2)) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pc_q    <= RESET_PC;
      skip_lo <= 1'b0;
      for (int i = 0; i < DEPTH; i++) pq[i] <= '0;
    end else if (redirect) begin
      cnt     <= '0;
      pc_q    <= {redirect_pc[PC_W-1:1], 1'b0};
      skip_lo <= redirect_pc[1];
    end else begin
      for (int i = 0; i < DEPTH; i++) pq[i] <= nq[i];
      cnt <= ncnt;
      if (fire) pc_q <= pc_q + (is16 ? PC_W'(2) : PC_W'(4));
      if (take) skip_lo <= 1'b0;
    end
  end

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !redirect |=>
      out_pc == $past(out_pc) + ($past(out_len32) ? PC_W'(4) : PC_W'(2)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !redirect |=>
      out_valid && $stable(out_instr) && $stable(out_pc));

  // R7
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !out_valid && !unsupported &&
      out_pc == ($past(redirect_pc) & ~PC_W'(1)));

  // R9
  long_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported && !redirect |=> unsupported && !out_valid);

  // R9
  no_long_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_instr[1:0] == 2'b11 && out_instr[4:2] == 3'b111));

endmodule

// File: tb/parcel_aligner_test.sv
module parcel_aligner_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, fetch_valid = 1'b0, redirect = 1'b0, out_ready = 1'b0;
  logic fetch_ready, out_valid, out_len32, unsupported;
  logic [31:0] fetch_word = '0, redirect_pc = '0, out_instr, out_pc;

  parcel_aligner #(.PC_W(32), .RESET_PC(32'h0)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_word(fetch_word), .redirect(redirect), .redirect_pc(redirect_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_pc(out_pc), .out_len32(out_len32), .unsupported(unsupported));

  localparam logic [31:0] TARGETS [8] = '{32'h0, 32'h2, 32'h106, 32'h1000,
                                          32'h7E, 32'h3332, 32'h400, 32'hA0A};

  int checks = 0, fails = 0, nout = 0, acc = 0;
  logic [31:0] epc = '0, faddr = '0, long_at = 32'hFFFF_FFF0;
  logic [15:0] long_code = 16'h001F;
  logic first = 1'b0, hold = 1'b0, fv_force = 1'b0, rdy_force = 1'b0;
  logic [31:0] hold_i, hold_p;

  function automatic logic [15:0] mem16(input logic [31:0] a);
    logic [15:0] h, v;
    h = a[16:1];
    v = (h * 16'h9E37) ^ (h << 5);
    if (a == long_at) return long_code;
    if (a == long_at - 32'd2 || a == long_at - 32'd4) return 16'h1111;
    if (v[3]) return {v[15:5], 3'(h % 16'd7), 2'b11};
    return {v[15:2], 2'(h % 16'd3)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit rnd);
    logic [15:0] p0;
    @(negedge clk);
    redirect    = 1'b0;
    out_ready   = rnd ? ($urandom % 4 != 0) : rdy_force;
    fetch_valid = rnd ? ($urandom % 3 != 0) : fv_force;
    fetch_word  = {mem16(faddr + 32'd2), mem16(faddr)};
    #1;
    if (hold) begin
      check("R6 valid", 32'(out_valid), 32'd1);
      check("R6 instr", out_instr, hold_i);
      check("R6 pc", out_pc, hold_p);
    end
    if (out_valid && out_ready) begin
      p0 = mem16(epc);
      check("R5 pc", out_pc, epc);
      if (p0[1:0] != 2'b11) begin
        check(first ? (epc[1] ? "R8 first" : "R7 first") : "R2 instr", out_instr, {16'h0, p0});
        check("R2 len", 32'(out_len32), 32'd0);
        epc += 32'd2;
      end else begin
        check(first ? (epc[1] ? "R8 first" : "R7 first") : (epc[1] ? "R4 straddle" : "R3 instr"),
              out_instr, {mem16(epc + 32'd2), p0});
        check("R3 len", 32'(out_len32), 32'd1);
        epc += 32'd4;
      end
      nout++;
      first = 1'b0;
    end
    hold   = out_valid && !out_ready;
    hold_i = out_instr;
    hold_p = out_pc;
    if (fetch_valid && fetch_ready) begin
      faddr += 32'd4;
      acc++;
    end
  endtask

  task automatic do_redirect(input logic [31:0] t);
    @(negedge clk);
    redirect = 1'b1; redirect_pc = t;
    fetch_valid = 1'b0; out_ready = 1'b0;
    hold = 1'b0; epc = t; faddr = {t[31:2], 2'b00}; first = 1'b1; acc = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 valid", 32'(out_valid), 32'd0);
    check("R1 unsupported", 32'(unsupported), 32'd0);
    check("R1 ready", 32'(fetch_ready), 32'd1);
    check("R1 pc", out_pc, 32'h0);

    for (int k = 0; k < 8; k++) begin
      do_redirect(TARGETS[k]);
      nout = 0;
      while (nout < 24) cycle(1'b1);
    end

    foreach (TARGETS[k]) if (k < 2) begin
      do_redirect(32'h300 + TARGETS[k]);
      fv_force = 1'b1; rdy_force = 1'b0;
      repeat (6) cycle(1'b0);
      check("R10 ready", 32'(fetch_ready), 32'd0);
      check("R10 words", 32'(acc), 32'd2);
      nout = 0;
      while (nout < 10) cycle(1'b1);
    end

    long_at = 32'h500;
    for (int m = 0; m < 3; m++) begin
      long_code = (m == 0) ? 16'h001F : (m == 1) ? 16'h003F : 16'h707F;
      do_redirect(32'h4FC);
      repeat (40) cycle(1'b1);
      check("R9 reached", epc, 32'h500);
      check("R9 flag", 32'(unsupported), 32'd1);
      check("R9 valid", 32'(out_valid), 32'd0);
      check("R9 pc", out_pc, 32'h500);
    end
    long_at = 32'hFFFF_FFF0;
    do_redirect(32'h500);
    cycle(1'b0);
    check("R9 cleared", 32'(unsupported), 32'd0);
    nout = 0;
    while (nout < 10) cycle(1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule